// File: doc/BRIEF.md
# Symbol-to-Beat Packet Framer

This block gathers a stream of symbols, one per cycle under a valid/ready handshake, each tagged with a flag marking the final symbol of a packet. It packs them into wide beats of `SYMBOLS_PER_BEAT` symbols. Every beat it emits carries a start-of-packet flag, an end-of-packet flag and a count of unused trailing symbols. A parameter decides whether the earliest symbol of a beat occupies the most significant lane or the least significant lane. When the downstream side stalls, the packer holds its beat and stops taking symbols. Nothing is dropped or reordered.

A separate framing monitor sits on its own beat-level input. It watches any beat stream that uses the same start/end/empty convention, including the packer's own output looped back. It raises a sticky error flag when the framing on that stream is illegal. The flag clears only on reset.

Top module: `beat_framer`

## Requirements
- R1: A beat holds its symbols in arrival order. With `FIRST_SYM_HIGH`=1 the first symbol sits in the top lane (`out_data_o[SYMBOLS_PER_BEAT*BITS_PER_SYMBOL-1 -: BITS_PER_SYMBOL]`) and later symbols go to lower lanes. With `FIRST_SYM_HIGH`=0 the first symbol sits in lane 0 (`out_data_o[BITS_PER_SYMBOL-1:0]`) and later symbols go to higher lanes.
- R2: `out_sop_o` is 1 on the first beat of each packet and 0 on every other beat.
- R3: `out_eop_o` is 1 on the beat that holds the symbol marked by `in_last_i` and 0 otherwise. A packet of one beat shows sop and eop together.
- R4: `out_empty_o` is `clog2(SYMBOLS_PER_BEAT)` bits wide. On an eop beat it equals the number of unused lanes. On any other beat it is 0.
- R5: Unused lanes of an eop beat hold zero. They are the lanes after the last symbol in order, which means the low lanes when `FIRST_SYM_HIGH`=1 and the high lanes otherwise.
- R6: The first symbol of a packet may be accepted in the cycle right after the last symbol of the previous packet. A sop beat may be delivered in the cycle right after an eop beat.
- R7: While `out_valid_o`=1 and `out_ready_i`=0, the beat outputs stay unchanged. Every accepted symbol appears exactly once, in order.
- R8: `in_ready_o` equals `!out_valid_o || out_ready_i`. Input is refused while a completed beat waits.
- R9: The monitor flags a transferred beat without sop while no packet is open.
- R10: The monitor flags a transferred beat with sop while a packet is open.
- R11: The monitor flags a transferred beat with eop=0 and a nonzero empty. A nonzero empty with eop=1 is legal.
- R12: `chk_error_o` rises one cycle after a violating transfer and stays 1 until reset. A beat counts as transferred only when `chk_valid_i` and `chk_ready_i` are both 1.
- R13: After reset, `out_valid_o`=0, `in_ready_o`=1 and `chk_error_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Symbol present |
| in_ready_o | output | 1 | Symbol can be taken |
| in_data_i | input | BITS_PER_SYMBOL | Symbol value |
| in_last_i | input | 1 | Symbol ends its packet |
| out_valid_o | output | 1 | Beat present |
| out_ready_i | input | 1 | Downstream takes the beat |
| out_data_o | output | SYMBOLS_PER_BEAT*BITS_PER_SYMBOL | Packed beat |
| out_sop_o | output | 1 | First beat of packet |
| out_eop_o | output | 1 | Last beat of packet |
| out_empty_o | output | EMPTY_W | Unused lanes in eop beat |
| chk_valid_i | input | 1 | Monitored beat valid |
| chk_ready_i | input | 1 | Monitored beat ready |
| chk_sop_i | input | 1 | Monitored start flag |
| chk_eop_i | input | 1 | Monitored end flag |
| chk_empty_i | input | EMPTY_W | Monitored empty count |
| chk_error_o | output | 1 | Sticky framing error |

## Verification
The properties assume the handshake inputs carry defined values at every rising edge after the synchronized reset lifts. The hold-on-stall property also relies on `out_ready_i` being the only thing that can release a waiting beat. The stimulus meets both assumptions: it drives every input at the falling edge with known values, keeps a symbol on the bus until it is taken, and asserts reset only between phases, after the model has been cleared. The monitor inputs stay at zero while the packer is exercised, so the error flag can only come from the deliberate monitor sequences.

// File: rtl/beat_framer_pkg.sv
package beat_framer_pkg;

  // Width of a lane counter / empty field (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

  // Arrival position that fills a given lane.
  function automatic int unsigned lane_to_pos(input int unsigned lane,
                                              input int unsigned lanes,
                                              input bit first_high);
    return first_high ? (lanes - 1 - lane) : lane;
  endfunction

endpackage

// File: rtl/beat_framer_rst_sync.sv
module beat_framer_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/beat_framer_assembler.sv
module beat_framer_assembler #(
  parameter int unsigned SYMBOLS    = 4,
  parameter int unsigned BITS       = 8,
  parameter bit          FIRST_HIGH = 1'b1,
  parameter int unsigned CNT_W      = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_i,
  input  logic [BITS-1:0]         sym_i,
  input  logic                    last_i,
  output logic                    done_o,
  output logic [SYMBOLS*BITS-1:0] beat_o,
  output logic [CNT_W-1:0]        empty_o
);
  localparam int unsigned BEAT_W = SYMBOLS * BITS;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SYMBOLS - 1);

  logic [CNT_W-1:0]  pos_q, pos_d;
  logic [BEAT_W-1:0] buf_q, buf_d, merged;

  // Each lane takes the incoming symbol when the arrival position maps to it.
  for (genvar l = 0; l < SYMBOLS; l++) begin : g_lane
    localparam int unsigned LANE_POS =
      beat_framer_pkg::lane_to_pos(l, SYMBOLS, FIRST_HIGH);
    assign merged[l*BITS +: BITS] =
      (pos_q == CNT_W'(LANE_POS)) ? sym_i : buf_q[l*BITS +: BITS];
  end

  always_comb begin
    done_o  = take_i && (last_i || (pos_q == LAST_POS));
    empty_o = last_i ? (LAST_POS - pos_q) : '0;
    beat_o  = merged;
    pos_d   = pos_q;
    buf_d   = buf_q;
    if (take_i) begin
      if (done_o) begin
        pos_d = '0;
        buf_d = '0;
      end else begin
        pos_d = pos_q + 1'b1;
        buf_d = merged;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      buf_q <= '0;
    end else if (take_i) begin
      pos_q <= pos_d;
      buf_q <= buf_d;
    end
  end
endmodule

// File: rtl/beat_framer_out_stage.sv
module beat_framer_out_stage #(
  parameter int unsigned BEAT_W = 32,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] data_i,
  input  logic              eop_i,
  input  logic [CNT_W-1:0]  empty_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic [BEAT_W-1:0] data_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic [CNT_W-1:0]  empty_o
);
  logic              valid_q, valid_d;
  logic              first_q, first_d;
  logic [BEAT_W-1:0] data_q;
  logic              sop_q, eop_q;
  logic [CNT_W-1:0]  empty_q;

  always_comb begin
    free_o  = !valid_q || ready_i;
    valid_d = load_i ? 1'b1 : (ready_i ? 1'b0 : valid_q);
    first_d = load_i ? eop_i : first_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      first_q <= 1'b1;
    end else begin
      valid_q <= valid_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      sop_q   <= 1'b0;
      eop_q   <= 1'b0;
      empty_q <= '0;
    end else if (load_i) begin
      data_q  <= data_i;
      sop_q   <= first_q;
      eop_q   <= eop_i;
      empty_q <= empty_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign sop_o   = sop_q;
  assign eop_o   = eop_q;
  assign empty_o = empty_q;

  // R7: a stalled beat is held unchanged
  p_hold_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(sop_o)
                            && $stable(eop_o) && $stable(empty_o));

  // R7: a new beat is never written over a waiting one
  p_no_overwrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!valid_o || ready_i));

  // R4: empty is zero on beats without eop
  p_empty_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !eop_o |-> empty_o == '0);
endmodule

// File: rtl/beat_framer_checker.sv
module beat_framer_checker #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [CNT_W-1:0] empty_i,
  output logic             error_o
);
  logic fire;
  logic open_q, open_d;
  logic err_q, err_d;
  logic orphan, nested, bad_empty;

  always_comb begin
    fire      = valid_i && ready_i;
    orphan    = fire && !sop_i && !open_q;
    nested    = fire && sop_i && open_q;
    bad_empty = fire && !eop_i && (empty_i != '0);
    open_d    = fire ? !eop_i : open_q;
    err_d     = err_q || orphan || nested || bad_empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      err_q  <= err_d;
    end
  end

  assign error_o = err_q;

  // R12: the error flag never drops without reset
  p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);

  // R11: a nonzero empty on a non-eop transfer is reported
  p_flag_bad_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_i && !eop_i && (empty_i != '0) |=> error_o);
endmodule

// File: rtl/beat_framer.sv
module beat_framer #(
  parameter  int unsigned SYMBOLS_PER_BEAT = 4,
  parameter  int unsigned BITS_PER_SYMBOL  = 8,
  parameter  bit          FIRST_SYM_HIGH   = 1'b1,
  localparam int unsigned EMPTY_W = beat_framer_pkg::cnt_width(SYMBOLS_PER_BEAT),
  localparam int unsigned BEAT_W  = SYMBOLS_PER_BEAT * BITS_PER_SYMBOL
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [BITS_PER_SYMBOL-1:0] in_data_i,
  input  logic                       in_last_i,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic [BEAT_W-1:0]          out_data_o,
  output logic                       out_sop_o,
  output logic                       out_eop_o,
  output logic [EMPTY_W-1:0]         out_empty_o,
  input  logic                       chk_valid_i,
  input  logic                       chk_ready_i,
  input  logic                       chk_sop_i,
  input  logic                       chk_eop_i,
  input  logic [EMPTY_W-1:0]         chk_empty_i,
  output logic                       chk_error_o
);
  logic              rst_n;
  logic              take;
  logic              slot_free;
  logic              beat_done;
  logic [BEAT_W-1:0] beat_data;
  logic [EMPTY_W-1:0] beat_empty;

  beat_framer_rst_sync i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  assign in_ready_o = slot_free;
  assign take       = in_valid_i && slot_free;

  beat_framer_assembler #(
    .SYMBOLS    (SYMBOLS_PER_BEAT),
    .BITS       (BITS_PER_SYMBOL),
    .FIRST_HIGH (FIRST_SYM_HIGH),
    .CNT_W      (EMPTY_W)
  ) i_assembler (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .take_i  (take),
    .sym_i   (in_data_i),
    .last_i  (in_last_i),
    .done_o  (beat_done),
    .beat_o  (beat_data),
    .empty_o (beat_empty)
  );

  beat_framer_out_stage #(
    .BEAT_W (BEAT_W),
    .CNT_W  (EMPTY_W)
  ) i_out_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (beat_done),
    .data_i  (beat_data),
    .eop_i   (in_last_i),
    .empty_i (beat_empty),
    .ready_i (out_ready_i),
    .free_o  (slot_free),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .sop_o   (out_sop_o),
    .eop_o   (out_eop_o),
    .empty_o (out_empty_o)
  );

  beat_framer_checker #(
    .CNT_W (EMPTY_W)
  ) i_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .valid_i (chk_valid_i),
    .ready_i (chk_ready_i),
    .sop_i   (chk_sop_i),
    .eop_i   (chk_eop_i),
    .empty_i (chk_empty_i),
    .error_o (chk_error_o)
  );

  // R8: a waiting beat blocks the symbol input
  p_stall_blocks_input_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  // R3: a symbol marked last yields an eop beat on the next cycle
  p_last_gives_eop_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_valid_i && in_ready_o && in_last_i |=> out_valid_o && out_eop_o);
endmodule

// File: tb/test_beat_framer.sv
module test_beat_framer;
  localparam int SPB = 4;
  localparam int BPS = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic       in_valid, in_last, out_ready;
  logic [7:0] in_data;
  logic       chk_valid, chk_ready, chk_sop, chk_eop;
  logic [1:0] chk_empty;

  logic        in_ready_hi, ov_hi, sop_hi, eop_hi, err_hi;
  logic [31:0] od_hi;
  logic [1:0]  emp_hi;
  logic        in_ready_lo, ov_lo, sop_lo, eop_lo, err_lo;
  logic [31:0] od_lo;
  logic [1:0]  emp_lo;

  beat_framer #(.SYMBOLS_PER_BEAT(SPB), .BITS_PER_SYMBOL(BPS), .FIRST_SYM_HIGH(1'b1)) i_beat_framer (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready_hi), .in_data_i(in_data), .in_last_i(in_last),
    .out_valid_o(ov_hi), .out_ready_i(out_ready), .out_data_o(od_hi),
    .out_sop_o(sop_hi), .out_eop_o(eop_hi), .out_empty_o(emp_hi),
    .chk_valid_i(chk_valid), .chk_ready_i(chk_ready), .chk_sop_i(chk_sop),
    .chk_eop_i(chk_eop), .chk_empty_i(chk_empty), .chk_error_o(err_hi));

  beat_framer #(.SYMBOLS_PER_BEAT(SPB), .BITS_PER_SYMBOL(BPS), .FIRST_SYM_HIGH(1'b0)) i_beat_framer_lsb (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready_lo), .in_data_i(in_data), .in_last_i(in_last),
    .out_valid_o(ov_lo), .out_ready_i(out_ready), .out_data_o(od_lo),
    .out_sop_o(sop_lo), .out_eop_o(eop_lo), .out_empty_o(emp_lo),
    .chk_valid_i(chk_valid), .chk_ready_i(chk_ready), .chk_sop_i(chk_sop),
    .chk_eop_i(chk_eop), .chk_empty_i(chk_empty), .chk_error_o(err_lo));

  wire [35:0] obs_hi = {sop_hi, eop_hi, emp_hi, od_hi};
  wire [35:0] obs_lo = {sop_lo, eop_lo, emp_lo, od_lo};

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [35:0] q_hi[$];
  logic [35:0] q_lo[$];
  logic [7:0]  cur[$];
  bit          pkt_first;
  bit          stall_hi, stall_lo, prev_eop_hs;
  logic [35:0] held_hi, held_lo;
  int          r6_seen;
  int          rdy_pct;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_beat(input string who, input logic [35:0] act, input logic [35:0] exp);
    check(act[31:0] == exp[31:0], {"R1 R5 data ", who}, act[31:0], exp[31:0]);
    check(act[35] == exp[35], {"R2 sop ", who}, act[35], exp[35]);
    check(act[34] == exp[34], {"R3 eop ", who}, act[34], exp[34]);
    check(act[33:32] == exp[33:32], {"R4 empty ", who}, act[33:32], exp[33:32]);
  endtask

  task automatic model_push(input logic [7:0] d, input bit last);
    logic [31:0] dh, dl;
    logic [1:0]  emp;
    cur.push_back(d);
    if (last || cur.size() == SPB) begin
      dh = '0;
      dl = '0;
      foreach (cur[i]) begin
        dh[(SPB-1-i)*BPS +: BPS] = cur[i];
        dl[i*BPS +: BPS] = cur[i];
      end
      emp = last ? 2'(SPB - cur.size()) : 2'd0;
      q_hi.push_back({pkt_first, last, emp, dh});
      q_lo.push_back({pkt_first, last, emp, dl});
      pkt_first = last;
      cur.delete();
    end
  endtask

  task automatic model_clear();
    q_hi.delete();
    q_lo.delete();
    cur.delete();
    pkt_first   = 1'b1;
    stall_hi    = 1'b0;
    stall_lo    = 1'b0;
    prev_eop_hs = 1'b0;
  endtask

  function automatic bit pick_ready();
    return $urandom_range(99) < rdy_pct;
  endfunction

  task automatic step(input bit v, input logic [7:0] d, input bit l, input bit r, output bit acc);
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    in_last   = l;
    out_ready = r;
    #1;
    if (stall_hi) begin
      check(ov_hi, "R7 valid held hi", ov_hi, 1);
      check(obs_hi == held_hi, "R7 beat held hi", obs_hi, held_hi);
    end
    if (stall_lo) begin
      check(ov_lo, "R7 valid held lo", ov_lo, 1);
      check(obs_lo == held_lo, "R7 beat held lo", obs_lo, held_lo);
    end
    check(in_ready_hi == (!ov_hi || r), "R8 hi", in_ready_hi, !ov_hi || r);
    check(in_ready_lo == (!ov_lo || r), "R8 lo", in_ready_lo, !ov_lo || r);
    if (ov_hi && r) begin
      if (q_hi.size() == 0) check(0, "R7 unexpected beat hi", obs_hi, 0);
      else cmp_beat("hi", obs_hi, q_hi.pop_front());
      if (prev_eop_hs && sop_hi) r6_seen++;
      prev_eop_hs = eop_hi;
    end else begin
      prev_eop_hs = 1'b0;
    end
    if (ov_lo && r) begin
      if (q_lo.size() == 0) check(0, "R7 unexpected beat lo", obs_lo, 0);
      else cmp_beat("lo", obs_lo, q_lo.pop_front());
    end
    stall_hi = ov_hi && !r;
    stall_lo = ov_lo && !r;
    held_hi  = obs_hi;
    held_lo  = obs_lo;
    acc = v && in_ready_hi;
    if (acc) model_push(d, l);
  endtask

  task automatic send_pkt(input int len, input int gap_pct);
    bit acc;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      while ($urandom_range(99) < gap_pct) step(0, 8'h00, 0, pick_ready(), acc);
      do step(1, d, i == len - 1, pick_ready(), acc); while (!acc);
    end
  endtask

  task automatic drain();
    bit acc;
    for (int i = 0; i < 40; i++) step(0, 8'h00, 0, 1, acc);
    check(q_hi.size() == 0, "R7 no lost beat hi", q_hi.size(), 0);
    check(q_lo.size() == 0, "R7 no lost beat lo", q_lo.size(), 0);
    check(!ov_hi && !ov_lo, "R7 idle after drain", {ov_hi, ov_lo}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_last   = 1'b0;
    in_data   = '0;
    out_ready = 1'b0;
    chk_valid = 1'b0;
    chk_ready = 1'b0;
    chk_sop   = 1'b0;
    chk_eop   = 1'b0;
    chk_empty = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
  endtask

  task automatic chk_beat(input bit v, input bit r, input bit s, input bit e, input logic [1:0] emp);
    @(negedge clk);
    chk_valid = v;
    chk_ready = r;
    chk_sop   = s;
    chk_eop   = e;
    chk_empty = emp;
  endtask

  task automatic chk_expect(input bit exp, input string req);
    @(negedge clk);
    chk_valid = 1'b0;
    chk_ready = 1'b0;
    #1;
    check(err_hi == exp, {req, " hi"}, err_hi, exp);
    check(err_lo == exp, {req, " lo"}, err_lo, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    model_clear();
    r6_seen = 0;
    rdy_pct = 100;
    do_reset();

    // R13: reset state
    check(!ov_hi && !ov_lo, "R13 out_valid after reset", {ov_hi, ov_lo}, 0);
    check(in_ready_hi && in_ready_lo, "R13 in_ready after reset", {in_ready_hi, in_ready_lo}, 3);
    check(!err_hi && !err_lo, "R13 error after reset", {err_hi, err_lo}, 0);

    // R1 R3 R4 R5: every length from one to nine, no gaps, no stall
    for (int len = 1; len <= 9; len++) send_pkt(len, 0);
    // R6: single-symbol packets back to back
    for (int i = 0; i < 6; i++) send_pkt(1, 0);
    drain();
    check(r6_seen > 0, "R6 sop beat right after eop beat", r6_seen, 1);

    // R7 R8: random gaps and heavy backpressure
    rdy_pct = 40;
    for (int i = 0; i < 150; i++) send_pkt($urandom_range(1, 11), 30);
    rdy_pct = 100;
    drain();

    // R2: long packets with sink mostly ready
    rdy_pct = 85;
    for (int i = 0; i < 20; i++) send_pkt($urandom_range(9, 17), 10);
    rdy_pct = 100;
    drain();

    // Monitor: legal framing, including non-transfers that would be illegal
    do_reset();
    chk_beat(1, 1, 1, 0, 0);
    chk_beat(1, 1, 0, 0, 0);
    chk_beat(1, 1, 0, 1, 3);
    chk_beat(1, 1, 1, 1, 1);
    chk_beat(1, 0, 0, 0, 0);
    chk_beat(1, 0, 1, 0, 2);
    chk_expect(0, "R12 legal framing and non-transfers ignored (R9 R10 R11)");

    // R10: sop inside an open packet, then R12 sticky
    chk_beat(1, 1, 1, 0, 0);
    chk_beat(1, 1, 1, 0, 0);
    chk_expect(1, "R10 nested sop");
    chk_beat(1, 1, 0, 1, 0);
    chk_expect(1, "R12 error stays set");

    do_reset();
    chk_expect(0, "R12 reset clears error");
    chk_beat(1, 1, 0, 0, 0);
    chk_expect(1, "R9 beat without sop outside packet");

    do_reset();
    chk_beat(1, 1, 1, 0, 2);
    chk_expect(1, "R11 empty on non-eop beat");

    do_reset();
    chk_beat(1, 1, 1, 1, 2);
    chk_expect(0, "R11 empty on eop beat is legal");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule